// File: doc/BRIEF.md
# Four-Channel Output DAC Register Front End

This block is the serial-side register file of a four-channel industrial output converter. A host talks to it over a 24-bit SPI frame. Each frame either writes one register or asks for one register to be returned. The block keeps every per-channel and global setting and presents them on parallel ports for the analog and sequencing logic around it.

Writes and reads use two different address maps. A per-channel control address does not hold a single register. A 3-bit selector at the top of the data word picks one of several sub-registers behind it. Reads are pipelined. A read frame latches the selected register, and the value leaves on MISO during the next frame, whatever that next frame is. The usual follow-up is a no-op frame.

The SPI pins are sampled by the system clock through synchronizers. A frame only takes effect if exactly 24 SCLK rising edges were seen while chip select was low.

Top module: `dacSpiRegs`

## Requirements
- R1: Frames use SPI mode 0 (MOSI sampled on SCLK rise, MISO changed after SCLK fall), MSB first. In a 24-bit frame, bit 23 is the read flag, bits 20:16 the address and bits 15:0 the data; bits 22:21 are ignored.
- R2: A write to address 0b000cc stores the data word in channel cc's code register, 0b010cc in its gain register and 0b100cc in its offset register. The stored values appear on the channel's slices of `chanData`, `chanGain` and `chanOffset`.
- R3: A write to address 0b111cc is a control write. Data bits 15:13 select the target and bits 12:0 are the value. Selector 0 sets channel cc's slew word, 2 sets its DAC control word, 1 sets the global main word and 3 sets the global DC-DC word.
- R4: Control writes with selector 4, 5, 6 or 7 change no register. This includes the no-op frame 0x1CE000.
- R5: A read frame changes no register. Its target is latched when the frame ends and returned in bits 15:0 of the next frame's MISO stream, with bits 23:16 zero. The read map is: 0b000cc code, 0b001cc DAC control, 0b010cc gain, 0b011cc offset, 0b100cc clear code (always 0), 0b101cc slew, 0x18 status input, 0x19 main, 0x1A DC-DC, and 0 at every other address. 13-bit words are zero-extended.
- R6: A non-no-op frame that follows a read is still executed. The read data it shifts out is the value latched before its own write takes effect.
- R7: A frame with any SCLK count other than 24 is discarded. It changes no register and leaves the pending read data for the next frame unchanged.
- R8: After reset, every gain register is 0xFFFF, every offset register is 0x8000 and all other registers are 0. The first frame after reset returns 0 on MISO.
- R9: A committed frame that is not a read makes the next frame return 0 on MISO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the SPI pins are oversampled with it |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock from the host |
| csN | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI data from the host |
| miso | output | 1 | SPI data to the host |
| statusIn | input | 16 | Status word returned at read address 0x18 |
| chanData | output | NCH*16 | Per-channel code registers, channel 0 in the low slice |
| chanGain | output | NCH*16 | Per-channel gain registers |
| chanOffset | output | NCH*16 | Per-channel offset registers |
| chanSlew | output | NCH*13 | Per-channel slew words |
| chanDacCtrl | output | NCH*13 | Per-channel DAC control words |
| mainCtrl | output | 13 | Global main word |
| dcdcCtrl | output | 13 | Global DC-DC word |

## Verification
A reference model in the bench follows every frame. The bench sweeps all 32 read addresses in back-to-back read chains, once from reset and once after each register has been written with a different, channel-dependent value. This separates the channel decode from the register-type decode and exposes unmapped addresses.

Control writes are swept over all eight selectors on every channel. After each one the parallel ports are compared, so a selector that is decoded wrongly or leaks a value shows up at once.

Two more patterns target the pipeline. A write placed directly after a read shows the ordering between capture and update. Frames of 23 and 25 clocks placed between a read and its no-op show whether the count check drops the frame and keeps the pending data.

// File: rtl/dacSpiPkg.sv
package dacSpiPkg;
  localparam int FRAME_W = 24;
  localparam int WORD_W  = 16;
  localparam int CTRL_W  = 13;
  localparam int ADDR_W  = 5;

  localparam logic [2:0] SUB_SLEW = 3'd0;
  localparam logic [2:0] SUB_MAIN = 3'd1;
  localparam logic [2:0] SUB_DAC  = 3'd2;
  localparam logic [2:0] SUB_DCDC = 3'd3;

  typedef struct packed {
    logic              commit;
    logic              isRead;
    logic [ADDR_W-1:0] addr;
    logic [WORD_W-1:0] data;
  } frameStrobe_t;
endpackage

// File: rtl/dacSpiCtrl.sv
module dacSpiCtrl
  import dacSpiPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              csNIn,
  input  logic              mosiIn,
  input  logic [WORD_W-1:0] readWord,
  output logic              misoOut,
  output frameStrobe_t      strobe
);
  localparam int CNT_MAX = FRAME_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [SYNC_STAGES:0]   sclkSy, csSy;
  logic [SYNC_STAGES-1:0] mosiSy;
  logic [CNT_W-1:0]       bitCnt;
  logic [FRAME_W-1:0]     rxShift, txShift;

  logic sclkRise, sclkFall, csFall, csRise, csLow;
  assign sclkRise = sclkSy[SYNC_STAGES-1] & ~sclkSy[SYNC_STAGES];
  assign sclkFall = ~sclkSy[SYNC_STAGES-1] & sclkSy[SYNC_STAGES];
  assign csLow    = ~csSy[SYNC_STAGES-1];
  assign csFall   = ~csSy[SYNC_STAGES-1] & csSy[SYNC_STAGES];
  assign csRise   = csSy[SYNC_STAGES-1] & ~csSy[SYNC_STAGES];
  assign misoOut  = txShift[FRAME_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSy  <= '0;
      csSy    <= '1;
      mosiSy  <= '0;
      bitCnt  <= '0;
      rxShift <= '0;
      txShift <= '0;
      strobe  <= '0;
    end else begin
      sclkSy <= {sclkSy[SYNC_STAGES-1:0], sclkIn};
      csSy   <= {csSy[SYNC_STAGES-1:0], csNIn};
      mosiSy <= {mosiSy[SYNC_STAGES-2:0], mosiIn};
      strobe.commit <= 1'b0;
      if (csFall) begin
        bitCnt  <= '0;
        txShift <= {{(FRAME_W-WORD_W){1'b0}}, readWord};
      end else if (csLow) begin
        if (sclkRise) begin
          rxShift <= {rxShift[FRAME_W-2:0], mosiSy[SYNC_STAGES-1]};
          if (bitCnt != CNT_W'(CNT_MAX)) bitCnt <= bitCnt + 1'b1;
        end
        if (sclkFall) txShift <= {txShift[FRAME_W-2:0], 1'b0};
      end
      if (csRise && bitCnt == CNT_W'(FRAME_W)) begin
        strobe.commit <= 1'b1;
        strobe.isRead <= rxShift[FRAME_W-1];
        strobe.addr   <= rxShift[WORD_W+ADDR_W-1:WORD_W];
        strobe.data   <= rxShift[WORD_W-1:0];
      end
    end
  end

  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> !strobe.commit); // R1
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(CNT_MAX)); // R7
  AST_TX_HEAD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    csFall |=> (txShift[FRAME_W-1:WORD_W] == '0)); // R5
endmodule

// File: rtl/dacRegBank.sv
module dacRegBank
  import dacSpiPkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  frameStrobe_t            strobe,
  input  logic [WORD_W-1:0]       statusIn,
  output logic [WORD_W-1:0]       readWord,
  output logic [NCH*WORD_W-1:0]   dataOut,
  output logic [NCH*WORD_W-1:0]   gainOut,
  output logic [NCH*WORD_W-1:0]   offsetOut,
  output logic [NCH*CTRL_W-1:0]   slewOut,
  output logic [NCH*CTRL_W-1:0]   dacCtrlOut,
  output logic [CTRL_W-1:0]       mainOut,
  output logic [CTRL_W-1:0]       dcdcOut
);
  localparam logic [WORD_W-1:0] GAIN_RST   = '1;
  localparam logic [WORD_W-1:0] OFFSET_RST = WORD_W'(1) << (WORD_W - 1);

  logic [NCH-1:0][WORD_W-1:0] dataR, gainR, offR;
  logic [NCH-1:0][CTRL_W-1:0] slewR, dacR;
  logic [CTRL_W-1:0]          mainR, dcdcR;
  logic [WORD_W-1:0]          readLatch, rdVal;
  logic [1:0]                 ch;
  logic                       chValid;
  logic [2:0]                 sel;

  assign ch      = strobe.addr[1:0];
  assign chValid = int'(ch) < NCH;
  assign sel     = strobe.data[WORD_W-1:CTRL_W];

  assign dataOut    = dataR;
  assign gainOut    = gainR;
  assign offsetOut  = offR;
  assign slewOut    = slewR;
  assign dacCtrlOut = dacR;
  assign mainOut    = mainR;
  assign dcdcOut    = dcdcR;
  assign readWord   = readLatch;

  always_comb begin
    rdVal = '0;
    case (strobe.addr[4:2])
      3'b000: if (chValid) rdVal = dataR[ch];
      3'b001: if (chValid) rdVal = {{(WORD_W-CTRL_W){1'b0}}, dacR[ch]};
      3'b010: if (chValid) rdVal = gainR[ch];
      3'b011: if (chValid) rdVal = offR[ch];
      3'b101: if (chValid) rdVal = {{(WORD_W-CTRL_W){1'b0}}, slewR[ch]};
      3'b110: begin
        case (ch)
          2'd0:    rdVal = statusIn;
          2'd1:    rdVal = {{(WORD_W-CTRL_W){1'b0}}, mainR};
          2'd2:    rdVal = {{(WORD_W-CTRL_W){1'b0}}, dcdcR};
          default: rdVal = '0;
        endcase
      end
      default: rdVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataR     <= '0;
      for (int i = 0; i < NCH; i++) begin
        gainR[i] <= GAIN_RST;
        offR[i]  <= OFFSET_RST;
      end
      slewR     <= '0;
      dacR      <= '0;
      mainR     <= '0;
      dcdcR     <= '0;
      readLatch <= '0;
    end else if (strobe.commit) begin
      if (strobe.isRead) begin
        readLatch <= rdVal;
      end else begin
        readLatch <= '0;
        if (chValid) begin
          case (strobe.addr[4:2])
            3'b000: dataR[ch] <= strobe.data;
            3'b010: gainR[ch] <= strobe.data;
            3'b100: offR[ch]  <= strobe.data;
            3'b111: begin
              case (sel)
                SUB_SLEW: slewR[ch] <= strobe.data[CTRL_W-1:0];
                SUB_MAIN: mainR     <= strobe.data[CTRL_W-1:0];
                SUB_DAC:  dacR[ch]  <= strobe.data[CTRL_W-1:0];
                SUB_DCDC: dcdcR     <= strobe.data[CTRL_W-1:0];
                default: ;
              endcase
            end
            default: ;
          endcase
        end
      end
    end
  end

  logic [3*NCH*WORD_W+2*NCH*CTRL_W+2*CTRL_W-1:0] regImage;
  assign regImage = {dataR, gainR, offR, slewR, dacR, mainR, dcdcR};

  AST_INERT_SELECTOR: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && !strobe.isRead && strobe.addr[4:2] == 3'b111 && strobe.data[WORD_W-1])
      |=> $stable(regImage)); // R4
  AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && strobe.isRead) |=> $stable(regImage)); // R5
  AST_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(regImage)); // R7
  AST_PENDING_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(readLatch)); // R7
endmodule

// File: rtl/dacSpiRegs.sv
module dacSpiRegs
  import dacSpiPkg::*;
#(
  parameter int NCH         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclk,
  input  logic                  csN,
  input  logic                  mosi,
  output logic                  miso,
  input  logic [WORD_W-1:0]     statusIn,
  output logic [NCH*WORD_W-1:0] chanData,
  output logic [NCH*WORD_W-1:0] chanGain,
  output logic [NCH*WORD_W-1:0] chanOffset,
  output logic [NCH*CTRL_W-1:0] chanSlew,
  output logic [NCH*CTRL_W-1:0] chanDacCtrl,
  output logic [CTRL_W-1:0]     mainCtrl,
  output logic [CTRL_W-1:0]     dcdcCtrl
);
  frameStrobe_t      strobe;
  logic [WORD_W-1:0] readWord;

  dacSpiCtrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .sclkIn(sclk), .csNIn(csN), .mosiIn(mosi),
    .readWord(readWord), .misoOut(miso), .strobe(strobe)
  );

  dacRegBank #(.NCH(NCH)) i_bank (
    .clk(clk), .rstN(rstN), .strobe(strobe), .statusIn(statusIn),
    .readWord(readWord), .dataOut(chanData), .gainOut(chanGain),
    .offsetOut(chanOffset), .slewOut(chanSlew), .dacCtrlOut(chanDacCtrl),
    .mainOut(mainCtrl), .dcdcOut(dcdcCtrl)
  );
endmodule

// File: tb/test_dacSpiRegs.sv
module test_dacSpiRegs;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int NCH        = 4;

  logic clk = 0, rstN = 0, sclk = 0, csN = 1, mosi = 0;
  logic miso;
  logic [15:0] statusIn = 16'hA5C3;
  logic [NCH*16-1:0] chanData, chanGain, chanOffset;
  logic [NCH*13-1:0] chanSlew, chanDacCtrl;
  logic [12:0] mainCtrl, dcdcCtrl;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [15:0] mData[NCH], mGain[NCH], mOff[NCH];
  logic [12:0] mSlew[NCH], mDac[NCH];
  logic [12:0] mMain, mDcdc;
  logic [15:0] mPend;

  always #(CLK_PERIOD/2) clk = ~clk;

  dacSpiRegs i_dacSpiRegs (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso),
    .statusIn(statusIn), .chanData(chanData), .chanGain(chanGain),
    .chanOffset(chanOffset), .chanSlew(chanSlew), .chanDacCtrl(chanDacCtrl),
    .mainCtrl(mainCtrl), .dcdcCtrl(dcdcCtrl)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] modelRead(input logic [4:0] a);
    logic [1:0] c = a[1:0];
    case (a[4:2])
      3'd0: return mData[c];
      3'd1: return {3'b0, mDac[c]};
      3'd2: return mGain[c];
      3'd3: return mOff[c];
      3'd5: return {3'b0, mSlew[c]};
      3'd6: case (c)
              2'd0: return statusIn;
              2'd1: return {3'b0, mMain};
              2'd2: return {3'b0, mDcdc};
              default: return 16'h0;
            endcase
      default: return 16'h0;
    endcase
  endfunction

  task automatic modelApply(input logic [23:0] f);
    logic [4:0] a = f[20:16];
    logic [1:0] c = a[1:0];
    if (f[23]) begin
      mPend = modelRead(a);
    end else begin
      mPend = 16'h0;
      case (a[4:2])
        3'd0: mData[c] = f[15:0];
        3'd2: mGain[c] = f[15:0];
        3'd4: mOff[c]  = f[15:0];
        3'd7: case (f[15:13])
                3'd0: mSlew[c] = f[12:0];
                3'd1: mMain    = f[12:0];
                3'd2: mDac[c]  = f[12:0];
                3'd3: mDcdc    = f[12:0];
                default: ;
              endcase
        default: ;
      endcase
    end
  endtask

  task automatic spiFrame(input logic [23:0] tx, input int nbits, output logic [23:0] rx);
    rx = '0;
    @(negedge clk) csN = 0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 24) ? tx[23-i] : 1'b0;
      repeat (HALF) @(negedge clk);
      sclk = 1;
      rx = {rx[22:0], miso};
      repeat (HALF) @(negedge clk);
      sclk = 0;
    end
    repeat (HALF) @(negedge clk);
    csN = 1;
    repeat (HALF + 4) @(negedge clk);
  endtask

  task automatic frame(input logic [23:0] tx);
    logic [23:0] rx;
    spiFrame(tx, 24, rx);
    chk("R1 R5 R9 miso word", rx, {8'h0, mPend});
    modelApply(tx);
  endtask

  task automatic checkPorts(input string req);
    for (int c = 0; c < NCH; c++) begin
      chk({req, " code"},   chanData[c*16 +: 16],   mData[c]);
      chk({req, " gain"},   chanGain[c*16 +: 16],   mGain[c]);
      chk({req, " offset"}, chanOffset[c*16 +: 16], mOff[c]);
      chk({req, " slew"},   chanSlew[c*13 +: 13],   mSlew[c]);
      chk({req, " dacctl"}, chanDacCtrl[c*13 +: 13], mDac[c]);
    end
    chk({req, " main"}, mainCtrl, mMain);
    chk({req, " dcdc"}, dcdcCtrl, mDcdc);
  endtask

  task automatic readSweep();
    for (int a = 0; a < 32; a++) frame({1'b1, 2'b00, 5'(a), 16'h0});
    frame(24'h1CE000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] rx;
    for (int c = 0; c < NCH; c++) begin
      mData[c] = 0; mGain[c] = 16'hFFFF; mOff[c] = 16'h8000; mSlew[c] = 0; mDac[c] = 0;
    end
    mMain = 0; mDcdc = 0; mPend = 0;
    repeat (5) @(negedge clk);
    rstN = 1;
    repeat (3) @(negedge clk);

    checkPorts("R8 reset");
    frame(24'h1CE000);           // R8: first frame returns zero
    readSweep();                 // R5 R8 reset values through read map

    for (int c = 0; c < NCH; c++) begin   // R2
      frame({3'b000, 5'(c),        16'h1234 + 16'(c) * 16'h1111});
      frame({3'b000, 5'(8 + c),    16'hF00F - 16'(c) * 16'h0101});
      frame({3'b000, 5'(16 + c),   16'h7FF0 + 16'(c) * 16'h0013});
      checkPorts("R2 write");
    end

    for (int c = 0; c < NCH; c++)         // R3 R4 all selectors
      for (int s = 0; s < 8; s++) begin
        frame({3'b000, 5'(28 + c), 3'(s), 13'h00A5 + 13'(s) * 13'h0111 + 13'(c) * 13'h3});
        checkPorts("R3 R4 control");
      end
    frame(24'h1CE000);
    checkPorts("R4 no-op");

    statusIn = 16'h3C5A;
    readSweep();                 // R5 full map after writes

    // R6: write right after a read returns pre-write value
    frame({8'h80, 16'h0});
    spiFrame({8'h00, 16'hBEEF}, 24, rx);
    chk("R6 pre-write value", rx, {8'h0, mPend});
    chk("R6 exact old code", rx[15:0], 16'h1234);
    modelApply({8'h00, 16'hBEEF});
    checkPorts("R6 write executed");
    frame({8'h80, 16'h0});
    frame(24'h1CE000);

    // R7: miscounted frames between read and no-op
    frame({8'h89, 16'h0});
    spiFrame({8'h01, 16'h5555}, 23, rx);
    spiFrame({8'h01, 16'h6666}, 25, rx);
    spiFrame({8'h09, 16'h0001}, 8, rx);
    checkPorts("R7 discarded");
    spiFrame(24'h1CE000, 24, rx);
    chk("R7 pending kept", rx, {8'h0, mPend});
    chk("R7 gain1 value", rx[15:0], 16'hEF0E);
    modelApply(24'h1CE000);

    // R9: write followed by frame returns zero
    frame({8'h03, 16'h0ABC});
    spiFrame(24'h1CE000, 24, rx);
    chk("R9 zero after write", rx, 24'h0);
    modelApply(24'h1CE000);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule